// File: doc/BRIEF.md
# Pipeline Hazard Controller

This block steers operand forwarding and pipeline interlocks for an in-order integer core with fetch, decode, execute, memory and writeback stages. It looks at the source register numbers of the instructions in decode and execute. It also looks at the destination register and write intent of the older instructions further down the pipe. From these it decides where each execute operand comes from and whether the front of the pipe must wait or be cleared. The datapath registers, muxes and register file are outside this block. They consume the selects and control strobes it produces.

Operand sources are chosen per operand, and the youngest producer wins. A load whose result is needed by the instruction directly behind it cannot be bypassed in time. For that case the controller holds the program counter and the fetch/decode register for one cycle and drops a bubble into the decode/execute register. The register file makes a value written in writeback readable in the same cycle, so that case is left to the register file. Fetch always continues sequentially. When execute resolves a branch as taken, the two younger instructions are cancelled and the program counter is redirected. A taken branch takes precedence over a load interlock raised in the same cycle.

Top module: `hz_unit`

## Requirements
- R1: When the memory-stage instruction writes a register (mem_wr=1), its destination is nonzero and it equals an execute source, that operand's select is 2'b10 (bypass from the memory stage).
- R2: When only the writeback-stage instruction writes a nonzero register equal to an execute source, that operand's select is 2'b01 (bypass from writeback).
- R3: When both the memory and the writeback stages match the same execute source, the select is 2'b10, so the younger result is used.
- R4: The select is 2'b00 (register file) when no stage matches, when the matching destination is register 0, or when the matching instruction's write flag is low; the value 2'b11 never appears.
- R5: When the execute-stage instruction is a load that writes a nonzero destination equal to decode rs1 or rs2, and no taken branch is present, hold_front and bubble_idex are both 1 in that cycle.
- R6: hold_front and bubble_idex are 0 when execute holds a non-load, a load to register 0, a load with its write flag low, or a load whose destination matches neither decode source.
- R7: A match between the writeback destination and a decode source never raises hold_front or bubble_idex.
- R8: When br_taken=1, flush_ifid, flush_idex and pc_redirect are all 1 in that cycle.
- R9: When br_taken=1 and a load-use condition is present together, hold_front and bubble_idex are 0.
- R10: When br_taken=0, flush_ifid, flush_idex and pc_redirect are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used to sample the built-in checks |
| rst_n | input | 1 | Asynchronous active-low reset for the checks |
| id_rs1 | input | 5 | First source register of the decode instruction |
| id_rs2 | input | 5 | Second source register of the decode instruction |
| ex_rs1 | input | 5 | First source register of the execute instruction |
| ex_rs2 | input | 5 | Second source register of the execute instruction |
| ex_rd | input | 5 | Destination of the execute instruction |
| ex_wr | input | 1 | Execute instruction writes a register |
| ex_load | input | 1 | Execute instruction is a load |
| mem_rd | input | 5 | Destination of the memory-stage instruction |
| mem_wr | input | 1 | Memory-stage instruction writes a register |
| wb_rd | input | 5 | Destination of the writeback instruction |
| wb_wr | input | 1 | Writeback instruction writes a register |
| br_taken | input | 1 | Branch in execute resolved as taken |
| fwd_a | output | 2 | Source select for execute operand 1 |
| fwd_b | output | 2 | Source select for execute operand 2 |
| hold_front | output | 1 | Hold program counter and fetch/decode register |
| bubble_idex | output | 1 | Load a no-op into the decode/execute register |
| flush_ifid | output | 1 | Cancel the instruction in the fetch/decode register |
| flush_idex | output | 1 | Cancel the instruction in the decode/execute register |
| pc_redirect | output | 1 | Take the branch target as the next program counter |

## Verification
Random register numbers are drawn from a narrow range so that destinations and sources collide often. This exercises single matches, double matches and matches on register 0 against the priority rules. Write and load flags are toggled independently of the register numbers. That separates a real producer from a matching number with no write behind it, and a load from an ordinary writer. Directed cases set up the exact corners: both stages hitting one source, the writeback-to-decode case, and a taken branch in the same cycle as a load interlock. These show whether precedence is resolved the right way round.

// File: rtl/hz_pkg.sv
package hz_pkg;
  localparam int unsigned REG_AW = 5;

  typedef enum logic [1:0] {
    SRC_RF  = 2'b00,
    SRC_WB  = 2'b01,
    SRC_MEM = 2'b10
  } fwd_e;
endpackage

// File: rtl/hz_fwd_sel.sv
module hz_fwd_sel #(
  parameter int unsigned AW = 5
) (
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_wr,
  input  logic [AW-1:0] wb_rd,
  input  logic          wb_wr,
  output hz_pkg::fwd_e  sel
);
  localparam logic [AW-1:0] ZERO_REG = '0;

  logic mem_hit;
  logic wb_hit;

  always_comb begin
    mem_hit = mem_wr && (mem_rd != ZERO_REG) && (mem_rd == src);
    wb_hit  = wb_wr  && (wb_rd  != ZERO_REG) && (wb_rd  == src);
  end

  // younger producer first
  always_comb begin
    if (mem_hit)     sel = hz_pkg::SRC_MEM;
    else if (wb_hit) sel = hz_pkg::SRC_WB;
    else             sel = hz_pkg::SRC_RF;
  end
endmodule

// File: rtl/hz_load_interlock.sv
module hz_load_interlock #(
  parameter int unsigned AW = 5
) (
  input  logic [AW-1:0] id_rs1,
  input  logic [AW-1:0] id_rs2,
  input  logic [AW-1:0] ex_rd,
  input  logic          ex_wr,
  input  logic          ex_load,
  output logic          lu_hit
);
  localparam logic [AW-1:0] ZERO_REG = '0;

  logic producer_ok;
  logic rs_match;

  always_comb begin
    producer_ok = ex_load && ex_wr && (ex_rd != ZERO_REG);
    rs_match    = (ex_rd == id_rs1) || (ex_rd == id_rs2);
    lu_hit      = producer_ok && rs_match;
  end
endmodule

// File: rtl/hz_branch_ctl.sv
module hz_branch_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic lu_hit,
  input  logic br_taken,
  output logic hold_front,
  output logic bubble_idex,
  output logic flush_ifid,
  output logic flush_idex,
  output logic pc_redirect
);
  // a taken branch discards the dependent instruction anyway
  always_comb begin
    hold_front  = lu_hit && !br_taken;
    bubble_idex = lu_hit && !br_taken;
    flush_ifid  = br_taken;
    flush_idex  = br_taken;
    pc_redirect = br_taken;
  end

  AST_FLUSH_BEATS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    flush_idex |-> (!hold_front && !bubble_idex)); // R9
  AST_HOLD_WITH_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    hold_front |-> bubble_idex); // R5
  AST_FLUSH_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    pc_redirect |-> (flush_ifid && flush_idex)); // R8
endmodule

// File: rtl/hz_unit.sv
module hz_unit #(
  parameter int unsigned AW = hz_pkg::REG_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] id_rs1,
  input  logic [AW-1:0] id_rs2,
  input  logic [AW-1:0] ex_rs1,
  input  logic [AW-1:0] ex_rs2,
  input  logic [AW-1:0] ex_rd,
  input  logic          ex_wr,
  input  logic          ex_load,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_wr,
  input  logic [AW-1:0] wb_rd,
  input  logic          wb_wr,
  input  logic          br_taken,
  output logic [1:0]    fwd_a,
  output logic [1:0]    fwd_b,
  output logic          hold_front,
  output logic          bubble_idex,
  output logic          flush_ifid,
  output logic          flush_idex,
  output logic          pc_redirect
);
  localparam int unsigned NSRC = 2;
  localparam logic [AW-1:0] ZERO_REG = '0;

  logic [NSRC-1:0][AW-1:0] ex_src;
  hz_pkg::fwd_e            sel [NSRC];
  logic                    lu_hit;

  always_comb begin
    ex_src[0] = ex_rs1;
    ex_src[1] = ex_rs2;
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    hz_fwd_sel #(.AW(AW)) u_sel (
      .src    (ex_src[g]),
      .mem_rd (mem_rd),
      .mem_wr (mem_wr),
      .wb_rd  (wb_rd),
      .wb_wr  (wb_wr),
      .sel    (sel[g])
    );
  end

  always_comb begin
    fwd_a = sel[0];
    fwd_b = sel[1];
  end

  hz_load_interlock #(.AW(AW)) u_lu (
    .id_rs1  (id_rs1),
    .id_rs2  (id_rs2),
    .ex_rd   (ex_rd),
    .ex_wr   (ex_wr),
    .ex_load (ex_load),
    .lu_hit  (lu_hit)
  );

  hz_branch_ctl u_br (
    .clk         (clk),
    .rst_n       (rst_n),
    .lu_hit      (lu_hit),
    .br_taken    (br_taken),
    .hold_front  (hold_front),
    .bubble_idex (bubble_idex),
    .flush_ifid  (flush_ifid),
    .flush_idex  (flush_idex),
    .pc_redirect (pc_redirect)
  );

  AST_FWD_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_a != 2'b11) && (fwd_b != 2'b11)); // R4
  AST_MEM_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && mem_rd != ZERO_REG && mem_rd == ex_rs1) |-> (fwd_a == 2'b10)); // R3
  AST_NO_FWD_X0: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_rs1 == ZERO_REG) |-> (fwd_a == 2'b00)); // R4
  AST_NO_HOLD_X0: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_rd == ZERO_REG || !ex_load) |-> !hold_front); // R6
  AST_IDLE_NO_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    !br_taken |-> !(flush_ifid || flush_idex || pc_redirect)); // R10
endmodule

// File: tb/sim_hz_unit.sv
module sim_hz_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
  logic ex_wr, ex_load, mem_wr, wb_wr, br_taken;
  logic [1:0] fwd_a, fwd_b;
  logic hold_front, bubble_idex, flush_ifid, flush_idex, pc_redirect;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  hz_unit u0 (.*);

  function automatic logic [1:0] exp_fwd(input logic [4:0] s);
    if (mem_wr && mem_rd != 0 && mem_rd == s) return 2'b10;
    if (wb_wr && wb_rd != 0 && wb_rd == s) return 2'b01;
    return 2'b00;
  endfunction

  function automatic string fwd_tag(input logic [4:0] s);
    bit m, w;
    m = mem_wr && mem_rd != 0 && mem_rd == s;
    w = wb_wr && wb_rd != 0 && wb_rd == s;
    if (m && w) return "R3";
    if (m) return "R1";
    if (w) return "R2";
    return "R4";
  endfunction

  function automatic bit exp_lu();
    return ex_load && ex_wr && ex_rd != 0 && (ex_rd == id_rs1 || ex_rd == id_rs2);
  endfunction

  task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_all();
    bit lu;
    string st;
    lu = exp_lu();
    chk(fwd_tag(ex_rs1), fwd_a, exp_fwd(ex_rs1));
    chk(fwd_tag(ex_rs2), fwd_b, exp_fwd(ex_rs2));
    st = br_taken ? (lu ? "R9" : "R8") : (lu ? "R5" : "R6");
    chk(st, {1'b0, hold_front}, {1'b0, lu && !br_taken});
    chk(st, {1'b0, bubble_idex}, {1'b0, lu && !br_taken});
    st = br_taken ? "R8" : "R10";
    chk(st, {1'b0, flush_ifid}, {1'b0, br_taken});
    chk(st, {1'b0, flush_idex}, {1'b0, br_taken});
    chk(st, {1'b0, pc_redirect}, {1'b0, br_taken});
  endtask

  task automatic apply(input logic [4:0] i1, i2, e1, e2, erd, input logic ew, el,
                       input logic [4:0] mrd, input logic mw,
                       input logic [4:0] wrd, input logic ww, input logic bt);
    @(negedge clk);
    id_rs1 = i1; id_rs2 = i2; ex_rs1 = e1; ex_rs2 = e2; ex_rd = erd;
    ex_wr = ew; ex_load = el; mem_rd = mrd; mem_wr = mw; wb_rd = wrd; wb_wr = ww;
    br_taken = bt;
    #5;
    check_all();
  endtask

  initial begin
    id_rs1 = 0; id_rs2 = 0; ex_rs1 = 0; ex_rs2 = 0; ex_rd = 0; mem_rd = 0; wb_rd = 0;
    ex_wr = 0; ex_load = 0; mem_wr = 0; wb_wr = 0; br_taken = 0;
    #15;
    check_all(); // reset state: R4 / R10
    @(negedge clk); rst_n = 1'b1;
    // R1 memory bypass on operand 1
    apply(1, 2, 3, 4, 0, 0, 0, 3, 1, 0, 0, 0);
    // R2 writeback bypass on operand 2
    apply(1, 2, 3, 4, 0, 0, 0, 0, 0, 4, 1, 0);
    // R3 both stages match the same source
    apply(1, 2, 5, 5, 0, 0, 0, 5, 1, 5, 1, 0);
    // R4 match on register 0 and on a non-writer
    apply(0, 0, 0, 6, 0, 0, 0, 0, 1, 6, 0, 0);
    // R5 load-use on rs2
    apply(7, 9, 1, 1, 9, 1, 1, 0, 0, 0, 0, 0);
    // R6 load to x0, non-load writer
    apply(0, 0, 1, 1, 0, 1, 1, 0, 0, 0, 0, 0);
    apply(8, 2, 1, 1, 8, 1, 0, 0, 0, 0, 0, 0);
    // R7 writeback-to-decode match only
    apply(11, 12, 1, 1, 0, 0, 0, 0, 0, 11, 1, 0);
    // R8 taken branch alone, R9 taken branch with load-use
    apply(1, 2, 3, 4, 0, 0, 0, 0, 0, 0, 0, 1);
    apply(13, 2, 3, 4, 13, 1, 1, 0, 0, 0, 0, 1);
    // random mix, narrow register range for frequent collisions
    void'($urandom(32'd1234));
    for (int k = 0; k < 600; k++) begin
      apply($urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3),
            $urandom_range(0, 3), $urandom_range(0, 3), 1'($urandom), 1'($urandom),
            $urandom_range(0, 3), 1'($urandom), $urandom_range(0, 3), 1'($urandom),
            1'($urandom_range(0, 4) == 0));
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule